// File: doc/BRIEF.md
# Macropixel Hit Latch with Gray Time-Stamp Capture

This block holds the event-definition logic at the front of a pixel readout chip. The only clock it takes is the read clock. A divider shared by the whole chip slows that clock down to a beam-crossing tick. Each tick advances a chip-wide time stamp, and the stamp is presented in Gray code. The block then assigns every pixel hit to the time-stamp interval in which the hit arrived. It does not use a fixed delay after the first hit to make that assignment.

The pixels are grouped four to a macropixel. Each macropixel collects the OR of its pixel hits over the current interval. When the interval closes at a tick, every macropixel that saw any hit freezes. On freezing it stores the pattern of pixels that fired and the time stamp of the interval that just ended. A frozen macropixel ignores new hits. It shows a valid flag, its pattern and its stamp to the readout side, and stays that way until the readout acknowledges it by index. The readout controller can restart the time stamp and the divider with a single-cycle command.

Top module: `mpx_hit_latch`

## Requirements
- R1: `bc_tick` is high for exactly one read-clock cycle in every `DIV_RATIO` cycles (default 16). After reset or after a time-stamp restart, the first pulse comes in the 16th cycle.
- R2: `ts_gray` changes only in the cycle after a tick. Its value is the Gray code `b ^ (b >> 1)` of a 4-bit binary count of ticks, which wraps from 15 to 0. Two consecutive values differ in exactly one bit.
- R3: When `ts_rst` is high in a cycle, the next cycle shows `ts_gray` = 0 and restarts the divider phase. This takes precedence over a tick in the same cycle.
- R4: The hit flag of macropixel m is the OR of `pix_hit[4m+3:4m]`. While m is not frozen, `mp_pattern[4m+i]` reports whether pixel i fired at any time in the closing interval.
- R5: In a tick cycle, every unfrozen macropixel that has collected at least one hit becomes valid in the next cycle. This includes a hit that arrives in the tick cycle itself. Its `mp_ts` then equals the `ts_gray` value that was shown during the tick cycle.
- R6: A macropixel that received no hits during an interval remains invalid across the tick, with `mp_pattern` and `mp_ts` at 0.
- R7: A frozen macropixel ignores pixel hits. Its valid flag, pattern and stamp hold until it is acknowledged, and hits received while frozen do not appear after it is released.
- R8: An acknowledge (`ack_valid` high with `ack_idx` = m) on a frozen macropixel m clears it in the next cycle, and its pattern and stamp read 0. Hits to m in the acknowledge cycle are dropped. An acknowledge on an unfrozen macropixel has no effect, and other macropixels are never affected.
- R9: While `rst_n` is low, at the next clock edge all valid flags, patterns and stamps clear to 0, `ts_gray` becomes 0 and the divider phase restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_rst | input | 1 | Time-stamp restart command from the readout controller |
| pix_hit | input | 4*N_MPX | Pixel hit inputs, pixel i of macropixel m at bit 4m+i |
| ack_valid | input | 1 | Readout acknowledge strobe |
| ack_idx | input | $clog2(N_MPX) | Index of the macropixel being acknowledged |
| bc_tick | output | 1 | Beam-crossing tick, high in the last cycle of each interval |
| ts_gray | output | 4 | Current Gray-coded time stamp |
| mp_valid | output | N_MPX | Frozen/valid flag per macropixel |
| mp_pattern | output | 4*N_MPX | Captured pixel pattern per macropixel |
| mp_ts | output | 4*N_MPX | Captured time stamp per macropixel, bits 4m+3:4m |

## Verification
Two kinds of event can land in the same cycle as a tick. A pixel hit can arrive in the tick cycle and has to count toward the stamp that is ending. An acknowledge can also arrive in the tick cycle, and it has to win over a new capture. The bench waits until it sees `bc_tick` high and then drives a hit or an acknowledge in that same cycle. It judges the result against an arithmetic model of the interval count and the Gray code. A long pseudo-random phase also places hits, acknowledges and time-stamp restarts on tick cycles, and checks every cycle against that model.

// File: rtl/mpx_pkg.sv
// Package: constants and helper functions shared by the macropixel latch.
// Assumes the fixed group of four pixels per macropixel and a 4-bit stamp.
package mpx_pkg;

    localparam int PIX_PER_MPX = 4;
    localparam int TS_W        = 4;

    typedef logic [TS_W-1:0]        ts_t;
    typedef logic [PIX_PER_MPX-1:0] pix_t;

    // Binary-to-Gray conversion of a time-stamp count.
    function automatic ts_t bin2gray(input ts_t b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/mpx_bc_div.sv
// Module: beam-crossing divider. It counts read-clock cycles and pulses a
// one-cycle tick in the last cycle of each DIV_RATIO-cycle interval.
// Assumes DIV_RATIO >= 2; the restart command resets the phase.
module mpx_bc_div #(
    parameter int DIV_RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt;

    // Divider phase counter, wrapping at DIV_RATIO.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick marks the final cycle of the interval.
    always_comb begin
        tick = (cnt == LAST);
    end
endmodule

// File: rtl/mpx_ts_gray.sv
// Module: chip-wide time-stamp counter. It keeps a binary count of ticks
// and presents it in Gray code. Assumes the tick is a one-cycle enable;
// the restart command takes precedence over a tick.
module mpx_ts_gray
    import mpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output ts_t  ts_gray
);
    ts_t ts_bin;

    // Binary stamp count advancing once per beam-crossing tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ts_bin <= '0;
        end else if (tick) begin
            ts_bin <= ts_bin + 1'b1;
        end
    end

    // Gray view of the count so that adjacent stamps differ in one bit.
    always_comb begin
        ts_gray = bin2gray(ts_bin);
    end
endmodule

// File: rtl/mpx_cell.sv
// Module: one macropixel. It accumulates the per-pixel hits of the open
// interval. At a tick it freezes if any pixel fired, storing the pattern
// and the ending stamp. A frozen cell ignores hits until it is
// acknowledged. Assumes the acknowledge is already decoded for this cell.
module mpx_cell
    import mpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  pix_t pix,
    input  logic tick,
    input  ts_t  ts_now,
    input  logic ack_sel,
    output logic valid,
    output pix_t pattern,
    output ts_t  ts_cap
);
    pix_t acc_q;
    pix_t acc_next;
    logic hit_or;
    logic frozen_q;
    logic release_now;
    logic freeze_now;

    // Combine stored hits with hits arriving this cycle.
    always_comb begin
        acc_next    = acc_q | pix;
        hit_or      = |acc_next;
        release_now = ack_sel && frozen_q;
        freeze_now  = !frozen_q && tick && hit_or;
    end

    // Freeze/release state and the captured pattern and stamp.
    always_ff @(posedge clk) begin
        if (!rst_n || release_now) begin
            frozen_q <= 1'b0;
            pattern  <= '0;
            ts_cap   <= '0;
        end else if (freeze_now) begin
            frozen_q <= 1'b1;
            pattern  <= acc_next;
            ts_cap   <= ts_now;
        end
    end

    // Interval accumulator: open only while the cell is not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n || frozen_q || tick) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_next;
        end
    end

    // Valid flag mirrors the frozen state.
    always_comb begin
        valid = frozen_q;
    end
endmodule

// File: rtl/mpx_hit_latch.sv
// Module: top of the macropixel hit latch. It ties the shared divider and
// the Gray stamp to N_MPX macropixel cells and decodes the readout
// acknowledge by index. Assumes N_MPX >= 2 and a single read clock.
module mpx_hit_latch
    import mpx_pkg::*;
#(
    parameter int N_MPX     = 8,
    parameter int DIV_RATIO = 16,
    localparam int IDX_W    = $clog2(N_MPX),
    localparam int PIX_W    = N_MPX * PIX_PER_MPX,
    localparam int TSV_W    = N_MPX * TS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_rst,
    input  logic [PIX_W-1:0] pix_hit,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    output logic             bc_tick,
    output logic [TS_W-1:0]  ts_gray,
    output logic [N_MPX-1:0] mp_valid,
    output logic [PIX_W-1:0] mp_pattern,
    output logic [TSV_W-1:0] mp_ts
);
    ts_t ts_now;

    mpx_bc_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ts_rst),
        .tick    (bc_tick)
    );

    mpx_ts_gray u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ts_rst),
        .tick    (bc_tick),
        .ts_gray (ts_now)
    );

    // Publish the running stamp.
    always_comb begin
        ts_gray = ts_now;
    end

    for (genvar m = 0; m < N_MPX; m++) begin : g_cell
        logic sel;
        pix_t pat;
        ts_t  tsc;

        // Decode the acknowledge index for this cell.
        always_comb begin
            sel = ack_valid && (ack_idx == IDX_W'(m));
        end

        mpx_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pix     (pix_hit[m*PIX_PER_MPX +: PIX_PER_MPX]),
            .tick    (bc_tick),
            .ts_now  (ts_now),
            .ack_sel (sel),
            .valid   (mp_valid[m]),
            .pattern (pat),
            .ts_cap  (tsc)
        );

        // Place cell outputs into the flat buses.
        always_comb begin
            mp_pattern[m*PIX_PER_MPX +: PIX_PER_MPX] = pat;
            mp_ts[m*TS_W +: TS_W]                    = tsc;
        end
    end
endmodule

// File: rtl/mpx_hit_latch_chk.sv
// Module: assertion checker bound to mpx_hit_latch.
module mpx_hit_latch_chk #(
    parameter int N_MPX = 8,
    localparam int IDX_W = $clog2(N_MPX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ts_rst,
    input logic               bc_tick,
    input logic [3:0]         ts_gray,
    input logic               ack_valid,
    input logic [IDX_W-1:0]   ack_idx,
    input logic [N_MPX-1:0]   mp_valid,
    input logic [N_MPX*4-1:0] mp_ts
);
    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_tick |=> !bc_tick);

    // R2
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_tick && !ts_rst) |=> ($countones(ts_gray ^ $past(ts_gray)) == 1));

    // R2
    gray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_tick && !ts_rst) |=> $stable(ts_gray));

    // R3
    ts_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_rst |=> (ts_gray == 4'd0));

    for (genvar m = 0; m < N_MPX; m++) begin : g_chk
        // R5
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mp_valid[m]) |-> ($past(bc_tick) && (mp_ts[m*4 +: 4] == $past(ts_gray))));

        // R7
        frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mp_valid[m] && !(ack_valid && ack_idx == IDX_W'(m)))
            |=> (mp_valid[m] && $stable(mp_ts[m*4 +: 4])));

        // R8
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mp_valid[m] && ack_valid && ack_idx == IDX_W'(m)) |=> !mp_valid[m]);
    end
endmodule

bind mpx_hit_latch mpx_hit_latch_chk #(.N_MPX(N_MPX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts_rst    (ts_rst),
    .bc_tick   (bc_tick),
    .ts_gray   (ts_gray),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .mp_valid  (mp_valid),
    .mp_ts     (mp_ts)
);

// File: tb/mpx_hit_latch_test.sv
module mpx_hit_latch_test;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int DIV = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ts_rst;
    logic [N*4-1:0] pix_hit;
    logic           ack_valid;
    logic [2:0]     ack_idx;
    logic           bc_tick;
    logic [3:0]     ts_gray;
    logic [N-1:0]   mp_valid;
    logic [N*4-1:0] mp_pattern;
    logic [N*4-1:0] mp_ts;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R9";

    // bench model state
    int         m_cnt;
    logic [3:0] m_ts;
    logic       m_val [N];
    logic [3:0] m_pat [N];
    logic [3:0] m_cap [N];
    logic [3:0] m_acc [N];
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpx_hit_latch #(.N_MPX(N), .DIV_RATIO(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .ts_rst(ts_rst), .pix_hit(pix_hit),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .bc_tick(bc_tick),
        .ts_gray(ts_gray), .mp_valid(mp_valid), .mp_pattern(mp_pattern),
        .mp_ts(mp_ts)
    );

    function automatic logic [3:0] gray(input logic [3:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // model update for one clock edge, from pre-edge inputs
    task automatic model_edge();
        bit tk;
        tk = (m_cnt == DIV - 1);
        if (!rst_n) begin
            m_cnt = 0; m_ts = 0;
            for (int m = 0; m < N; m++) begin
                m_val[m] = 0; m_pat[m] = 0; m_cap[m] = 0; m_acc[m] = 0;
            end
            return;
        end
        for (int m = 0; m < N; m++) begin
            logic [3:0] a;
            if (m_val[m]) begin
                if (ack_valid && ack_idx == 3'(m)) begin
                    m_val[m] = 0; m_pat[m] = 0; m_cap[m] = 0;
                end
                m_acc[m] = 0;
            end else begin
                a = m_acc[m] | pix_hit[m*4 +: 4];
                if (tk && a != 0) begin
                    m_val[m] = 1; m_pat[m] = a; m_cap[m] = gray(m_ts);
                end
                m_acc[m] = tk ? 4'd0 : a;
            end
        end
        if (ts_rst) begin
            m_cnt = 0; m_ts = 0;
        end else begin
            m_cnt = tk ? 0 : m_cnt + 1;
            if (tk) m_ts = m_ts + 1;
        end
    endtask

    task automatic compare();
        chk(bc_tick == (m_cnt == DIV - 1), "R1", "bc_tick", bc_tick, (m_cnt == DIV - 1));
        chk(ts_gray == gray(m_ts), (tag == "R3") ? "R3" : "R2", "ts_gray", ts_gray, gray(m_ts));
        for (int m = 0; m < N; m++) begin
            chk(mp_valid[m] == m_val[m], tag, "mp_valid", mp_valid[m], m_val[m]);
            chk(mp_pattern[m*4 +: 4] == m_pat[m], (tag == "R5") ? "R4" : tag,
                "mp_pattern", mp_pattern[m*4 +: 4], m_pat[m]);
            chk(mp_ts[m*4 +: 4] == m_cap[m], tag, "mp_ts", mp_ts[m*4 +: 4], m_cap[m]);
        end
    endtask

    task automatic step(input logic [N*4-1:0] h, input logic av,
                        input logic [2:0] ai, input logic tr);
        pix_hit = h; ack_valid = av; ack_idx = ai; ts_rst = tr;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic to_tick();
        while (!bc_tick) step('0, 1'b0, 3'd0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ts_rst = 0; pix_hit = '0; ack_valid = 0; ack_idx = '0;
        @(negedge clk);
        // R9: reset state
        tag = "R9";
        step('1, 1'b0, 3'd0, 1'b0);
        step('0, 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;

        // R1 R2 R6: idle cadence, Gray wrap after 16 intervals
        tag = "R6";
        idle(DIV * 18);

        // R4 R5: sweep every pixel of every macropixel at a varying phase
        tag = "R5";
        for (int m = 0; m < N; m++) begin
            for (int p = 0; p < 4; p++) begin
                to_tick();
                idle(1);
                idle((m * 4 + p) % DIV);
                step((N*4)'(1) << (m*4 + p), 1'b0, 3'd0, 1'b0);
                to_tick();
                idle(1);
                step('0, 1'b1, 3'(m), 1'b0);
            end
        end

        // R5: hit on the tick cycle itself, several pixels at once
        for (int m = 0; m < N; m++) begin
            to_tick();
            step((N*4)'(4'b1010) << (m*4), 1'b0, 3'd0, 1'b0);
            idle(2);
            step('0, 1'b1, 3'(m), 1'b0);
        end

        // R7: hits while frozen are ignored and do not reappear
        tag = "R7";
        step((N*4)'(4'b0001), 1'b0, 3'd0, 1'b0);
        to_tick(); idle(1);
        for (int i = 0; i < 20; i++) step((N*4)'(4'b1110), 1'b0, 3'd0, 1'b0);
        step('0, 1'b1, 3'd0, 1'b0);
        to_tick(); idle(2);

        // R8: ack on tick cycle, hit in ack cycle dropped, ack to idle cell
        tag = "R8";
        step((N*4)'(4'b0100) << 8, 1'b0, 3'd0, 1'b0);
        to_tick(); idle(1);
        to_tick();
        step((N*4)'(4'b1111) << 8, 1'b1, 3'd2, 1'b0);
        idle(1);
        step('0, 1'b1, 3'd5, 1'b0);
        step((N*4)'(4'b0011) << 20, 1'b1, 3'd5, 1'b0);
        to_tick(); idle(1);
        step('0, 1'b1, 3'd5, 1'b0);

        // R3: restart mid-interval and on a tick cycle
        tag = "R3";
        idle(5);
        step('0, 1'b0, 3'd0, 1'b1);
        idle(DIV + 3);
        to_tick();
        step((N*4)'(1) << 28, 1'b0, 3'd0, 1'b1);
        idle(DIV + 2);
        step('0, 1'b1, 3'd7, 1'b0);

        // mixed pseudo-random traffic, all requirements against the model
        tag = "R5";
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] a, b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = lfsr;
            step(a & b & (a >> 3), b[0] & b[5], b[10:8], (b[31:25] == 7'h11));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule